// File: doc/BRIEF.md
# Three-Wire Tuner Burst Writer

This block sends a configuration word of up to 24 bits to an external tuner over a three-wire link made of a serial clock, a serial data line and a latch strobe. Software sets the word length in bits. It then writes the word one byte at a time into a data register, most significant byte first. The word is left-aligned in 24 bits, so a 21-bit word fills the upper 21 bits and its last byte carries 3 padding bits.

The block holds one byte and shifts another at the same time. A status register reports two separate flags. One shows that the held byte has been taken and the next may be written. The other shows that bits are still held or on the wire. Only the programmed number of bits leaves the block, and any later bits or bytes are discarded. Once the word is complete, software sets and then clears a trigger bit, and the block raises the latch line for one serial-clock period.

Top module: `tuner_burst_writer`

## Requirements
- R1: After reset the status register (address 0) reads 0x40: bit 6 (ready) is 1, bit 7 (busy) is 0 and bit 1 (trigger) is 0. The length register (address 1) reads 0x15, and tw_sclk, tw_sdata and tw_latch are all low.
- R2: The length register at address 1 holds 5 bits (bits 4:0) and can be read back. The number of bits shifted per word is that value, limited to 24. A value of 0 shifts nothing.
- R3: A write to the data register (address 2) while ready is 1 is stored. From the next cycle ready reads 0 and busy reads 1. When the shifter takes the byte, ready returns to 1.
- R4: A byte written to address 2 while ready is 0 is dropped and never appears on tw_sdata.
- R5: Bits leave MSB first, in write order, taken from the 24-bit concatenation of the bytes (first byte in bits 23:16). Exactly the effective length is shifted. Unused bits of the last byte are discarded, and bytes written after the word is complete are dropped while ready stays 1.
- R6: tw_sclk idles low. Each serial bit has a low phase and a high phase of HALF = CLK_HZ/(2*SCLK_HZ) system cycles each. tw_sdata changes only while tw_sclk is low and holds steady while it is high.
- R7: Busy (status bit 7) is 1 while a byte is held or being shifted. It reads 0 from the cycle after the last bit's high phase ends.
- R8: Status bit 1 can be read and written. A write to address 0 with bit 1 = 0 while the stored bit is 1 fires the latch: tw_latch is high from the next cycle for 2*HALF cycles. Writing bit 1 = 1, or writing 0 while the stored bit is already 0, leaves tw_latch low.
- R9: A write to the length register, or a latch firing, starts a new word, so further bytes are accepted and shifted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 status/control, 1 length, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tw_sclk | output | 1 | Serial clock to the tuner |
| tw_sdata | output | 1 | Serial data, valid on the rising tw_sclk |
| tw_latch | output | 1 | Latch strobe that loads the shifted word |

## Verification
The ready and busy flags are sampled on the half cycle after the write that set them. Ready must read 0 one edge after a data write and 1 again one edge later when the shifter is idle. The latch must be high on the first sample after the clearing control write, and the bench counts its width in samples, expecting 2*HALF. Serial bits are captured at every low-to-high change of tw_sclk, and the high-phase width and data stability are checked per phase. Because of this, bit checks do not depend on how many idle cycles fall between bytes. Busy is polled until it clears, and only then are the captured bit count and values compared with the top bits of the written word.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    localparam int WORD_BITS = 24;
    localparam int LEN_W     = 5;
    localparam logic [LEN_W-1:0] LEN_RESET = 5'd21;

    localparam int BUSY_BIT  = 7;
    localparam int READY_BIT = 6;
    localparam int TRIG_BIT  = 1;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_LEN  = 2'd1,
        ADR_DATA = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_slot_t;

    // limit a programmed length to the 24-bit frame
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l > LEN_W'(WORD_BITS)) ? LEN_W'(WORD_BITS) : l;
    endfunction

    // number of bits of the next byte that still belong to the word
    function automatic logic [3:0] byte_take(input logic [LEN_W-1:0] eff,
                                             input logic [LEN_W-1:0] sent);
        logic [LEN_W-1:0] rem;
        rem = eff - sent;
        return (rem > LEN_W'(8)) ? 4'd8 : rem[3:0];
    endfunction

endpackage

// File: rtl/tbw_regs.sv
module tbw_regs
    import tbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             pop,
    input  logic             word_done,
    input  logic             shifting,
    output byte_slot_t       slot,
    output logic [LEN_W-1:0] eff_len,
    output logic             new_word,
    output logic             fire
);

    reg_addr_e        a;
    logic             we_ctrl, we_len, we_data, busy;
    logic [LEN_W-1:0] len_q;
    logic             trig_q;
    byte_slot_t       slot_q;

    always_comb begin
        a       = reg_addr_e'(addr);
        we_ctrl = we && (a == ADR_CTRL);
        we_len  = we && (a == ADR_LEN);
        we_data = we && (a == ADR_DATA);
    end

    assign fire     = we_ctrl && trig_q && !wdata[TRIG_BIT];
    assign new_word = fire || we_len;
    assign eff_len  = clamp_len(len_q);
    assign slot     = slot_q;
    assign busy     = shifting || slot_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= LEN_RESET;
            trig_q <= 1'b0;
            slot_q <= '0;
        end else begin
            if (we_len)  len_q  <= wdata[LEN_W-1:0];
            if (we_ctrl) trig_q <= wdata[TRIG_BIT];
            if (pop)     slot_q.valid <= 1'b0;
            if (we_data && !slot_q.valid && !word_done) begin
                slot_q.valid <= 1'b1;
                slot_q.data  <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (a)
            ADR_CTRL: begin
                rdata[BUSY_BIT]  = busy;
                rdata[READY_BIT] = !slot_q.valid;
                rdata[TRIG_BIT]  = trig_q;
            end
            ADR_LEN: rdata[LEN_W-1:0] = len_q;
            default: rdata = '0;
        endcase
    end

    // R3: an accepted byte occupies the holding slot on the next cycle
    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (we_data && !slot_q.valid && !word_done) |=> slot_q.valid);

    // R4: a write into a full slot leaves the held byte untouched
    p_drop_full_r4: assert property (@(posedge clk) disable iff (rst)
        (we_data && slot_q.valid) |=> $stable(slot_q.data));

endmodule

// File: rtl/tbw_shifter.sv
module tbw_shifter
    import tbw_pkg::*;
#(
    parameter int HALF = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_slot_t       slot,
    input  logic [LEN_W-1:0] eff_len,
    input  logic             new_word,
    output logic             pop,
    output logic             word_done,
    output logic             active,
    output logic             sclk,
    output logic             sdata
);

    localparam int DIV_W = (HALF < 2) ? 1 : $clog2(HALF);

    logic             active_q, sclk_q, tick;
    logic [7:0]       sh_q;
    logic [3:0]       left_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] sent_q;

    assign word_done = (sent_q >= eff_len);
    assign pop       = !active_q && slot.valid;
    assign tick      = (div_q == DIV_W'(HALF - 1));
    assign active    = active_q;
    assign sclk      = sclk_q;
    assign sdata     = active_q && sh_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            sh_q     <= '0;
            left_q   <= '0;
            div_q    <= '0;
            sent_q   <= '0;
        end else begin
            if (pop && !word_done) begin
                active_q <= 1'b1;
                sh_q     <= slot.data;
                left_q   <= byte_take(eff_len, sent_q);
                div_q    <= '0;
                sclk_q   <= 1'b0;
            end else if (active_q) begin
                if (tick) begin
                    div_q  <= '0;
                    sclk_q <= !sclk_q;
                    if (sclk_q) begin
                        sh_q   <= {sh_q[6:0], 1'b0};
                        left_q <= left_q - 4'd1;
                        sent_q <= sent_q + LEN_W'(1);
                        if (left_q == 4'd1) active_q <= 1'b0;
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
            if (new_word) sent_q <= '0;
        end
    end

    // R6: data holds while the serial clock stays high
    p_sdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(sdata));

    // R6: the serial clock is low whenever nothing is being shifted
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !sclk_q);

endmodule

// File: rtl/tbw_latch.sv
module tbw_latch #(
    parameter int PULSE = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic latch
);

    localparam int CW = $clog2(PULSE + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (fire)         cnt_q <= CW'(PULSE);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign latch = (cnt_q != '0);

    // R8: a firing write raises the strobe on the next cycle
    p_latch_start_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> latch);

    // R8: the strobe is never a single-cycle glitch
    p_latch_min_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(latch) |=> latch);

endmodule

// File: rtl/tuner_burst_writer.sv
module tuner_burst_writer
    import tbw_pkg::*;
#(
    parameter int CLK_HZ  = 250_000_000,
    parameter int SCLK_HZ = 500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tw_sclk,
    output logic       tw_sdata,
    output logic       tw_latch
);

    localparam int HALF_RAW = CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int PULSE    = 2 * HALF;

    byte_slot_t       slot;
    logic [LEN_W-1:0] eff_len;
    logic             new_word, fire, pop, word_done, shifting;

    tbw_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .pop       (pop),
        .word_done (word_done),
        .shifting  (shifting),
        .slot      (slot),
        .eff_len   (eff_len),
        .new_word  (new_word),
        .fire      (fire)
    );

    tbw_shifter #(.HALF(HALF)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .eff_len   (eff_len),
        .new_word  (new_word),
        .pop       (pop),
        .word_done (word_done),
        .active    (shifting),
        .sclk      (tw_sclk),
        .sdata     (tw_sdata)
    );

    tbw_latch #(.PULSE(PULSE)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .latch (tw_latch)
    );

endmodule

// File: tb/tuner_burst_writer_test.sv
module tuner_burst_writer_test;

    localparam int HALF  = 5;
    localparam int PULSE = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tw_sclk, tw_sdata, tw_latch;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tuner_burst_writer #(.CLK_HZ(250_000_000), .SCLK_HZ(25_000_000)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tw_sclk(tw_sclk), .tw_sdata(tw_sdata), .tw_latch(tw_latch)
    );

    // pin monitor, sampled away from the active edge
    logic [23:0] cap = '0;
    int   cap_n = 0, hi_run = 0, hi_bad = 0, lat_run = 0, lat_last = 0;
    logic prev_sclk = 1'b0, prev_sdata = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tw_sclk === 1'b1 && prev_sclk === 1'b0) begin
                if (cap_n < 24) cap[23 - cap_n] = tw_sdata;
                cap_n++;
            end
            if (tw_sclk === 1'b1) begin
                hi_run++;
                if (prev_sclk === 1'b1 && tw_sdata !== prev_sdata) hi_bad++;
            end
            if (tw_sclk === 1'b0 && prev_sclk === 1'b1) begin
                if (hi_run != HALF) hi_bad++;
                hi_run = 0;
            end
            if (tw_latch === 1'b1) lat_run++;
            else if (lat_run != 0) begin
                lat_last = lat_run;
                lat_run  = 0;
            end
            prev_sclk  = tw_sclk;
            prev_sdata = tw_sdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_flag(input int bitpos, input logic want, input string req);
        logic [7:0] s;
        bit seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd0, s);
            if (s[bitpos] == want) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        if (!seen) chk(1'b0, req, 0, 1);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // write a full word and compare what appears on the pins
    task automatic send_word(input bit set_len, input int len, input logic [23:0] w, input string req);
        int eff;
        logic [23:0] mask;
        if (set_len) wr(2'd1, len[7:0]);
        eff = (len > 24) ? 24 : len;
        cap_n = 0; hi_bad = 0;
        for (int b = 0; b < 3; b++) begin
            wait_flag(6, 1'b1, "R3");
            wr(2'd2, w[23 - 8*b -: 8]);
        end
        wait_flag(7, 1'b0, "R7");
        idle_cycles(2);
        mask = (eff == 0) ? 24'h0 : ~((24'h1 << (24 - eff)) - 24'h1);
        chk(cap_n == eff, {req, " bit count"}, cap_n, eff);
        chk((cap & mask) == (w & mask), {req, " bit values"}, int'(cap & mask), int'(w & mask));
        chk(hi_bad == 0, "R6 high phase width/stability", hi_bad, 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, s); chk(s == 8'h40, "R1 status", s, 8'h40);
        rd(2'd1, s); chk(s == 8'h15, "R1 length", s, 8'h15);
        chk({tw_sclk, tw_sdata, tw_latch} == 3'b000, "R1 pins", {tw_sclk, tw_sdata, tw_latch}, 0);

        // R2 R5 default length of 21 bits
        send_word(1'b0, 21, 24'hB7_3C_E9, "R2 R5 default length");

        // R3 ready/busy sequence around one accepted byte
        wr(2'd1, 8'd16);
        cap_n = 0;
        wr(2'd2, 8'hC3);
        rd(2'd0, s); chk(s == 8'h80, "R3 held byte", s, 8'h80);
        @(negedge clk);
        rd(2'd0, s); chk(s == 8'hC0, "R3 byte taken", s, 8'hC0);
        wait_flag(6, 1'b1, "R3");
        wr(2'd2, 8'h3C);
        wait_flag(7, 1'b0, "R7");
        idle_cycles(2);
        rd(2'd0, s); chk(s == 8'h40, "R7 idle after word", s, 8'h40);
        chk(cap_n == 16 && cap[23:8] == 16'hC33C, "R3 two bytes shifted", int'(cap[23:8]), 16'hC33C);

        // R4 back-to-back write: second byte lands while ready is low
        wr(2'd1, 8'd16);
        cap_n = 0;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h81;
        @(negedge clk);
        bus_wdata = 8'hFF;
        @(negedge clk);
        bus_we = 1'b0;
        wait_flag(6, 1'b1, "R3");
        wr(2'd2, 8'h24);
        wait_flag(7, 1'b0, "R7");
        idle_cycles(2);
        chk(cap_n == 16 && cap[23:8] == 16'h8124, "R4 dropped byte absent", int'(cap[23:8]), 16'h8124);

        // R5 R9 bytes after completion dropped, latch, then new word
        wr(2'd1, 8'd8);
        cap_n = 0;
        wr(2'd2, 8'h5A);
        wait_flag(7, 1'b0, "R7");
        wr(2'd2, 8'hFF);
        rd(2'd0, s); chk(s == 8'h40, "R5 extra byte not held", s, 8'h40);
        idle_cycles(4 * HALF);
        chk(cap_n == 8 && cap[23:16] == 8'h5A, "R5 word of 8 only", int'(cap[23:16]), 8'h5A);

        lat_last = 0;
        wr(2'd0, 8'h02);
        chk(tw_latch == 1'b0, "R8 set bit no fire", tw_latch, 0);
        rd(2'd0, s); chk(s == 8'h42, "R8 trigger readback", s, 8'h42);
        wr(2'd0, 8'h00);
        chk(tw_latch == 1'b1, "R8 latch next cycle", tw_latch, 1);
        idle_cycles(PULSE + 3);
        chk(lat_last == PULSE, "R8 latch width", lat_last, PULSE);
        lat_last = 0;
        wr(2'd0, 8'h00);
        idle_cycles(PULSE + 3);
        chk(lat_last == 0 && tw_latch == 1'b0, "R8 clear from 0 no fire", lat_last, 0);

        cap_n = 0;
        wr(2'd2, 8'h96);
        wait_flag(7, 1'b0, "R7");
        idle_cycles(2);
        chk(cap_n == 8 && cap[23:16] == 8'h96, "R9 new word after latch", int'(cap[23:16]), 8'h96);

        // R2 R5 sweep over every length code, including 0 and values above 24
        for (int len = 0; len < 32; len++) begin
            logic [23:0] w;
            w = {8'(8'hA5 ^ (len * 37)), 8'(8'h3C + len * 11), 8'(8'hF0 ^ (len * 5))};
            send_word(1'b1, len, w, "R2 R5 sweep");
            rd(2'd1, s);
            chk(s == 8'(len), "R2 length readback", s, len);
        end

        summary();
    end

endmodule